// File: doc/BRIEF.md
# Multiplexed Address/Data Management Register Port

This block is the management port of a line interface: a host processor reaches a small register file over one shared 8-bit address/data bus. The host first puts an address on the bus and drops the address strobe. The falling edge of that strobe latches the register number, and only the three low bus lines are decoded. The host then asserts an active-low chip select together with an active-low read strobe or write strobe to move one byte. All bus inputs are sampled on the block clock through one register stage. Two small state machines do the work. The bus controller has the states BUS_IDLE, BUS_READ and BUS_WRITE. The reference pulse generator has the states PL_IDLE and PL_ACTIVE.

Bus controller transitions:
- BUS_IDLE to BUS_READ when select and read are both low. This check takes precedence.
- BUS_IDLE to BUS_WRITE when select and write are both low.
- BUS_READ to BUS_IDLE when select or read goes high.
- BUS_WRITE to BUS_IDLE when write rises with select still low. This commits the byte.
- BUS_WRITE to BUS_IDLE when select rises first. This aborts the write and nothing is stored.

Pulse generator transitions:
- PL_IDLE to PL_ACTIVE on a trigger from the core.
- PL_ACTIVE to PL_IDLE when its down-counter reaches zero.

Toward the core the block exports every register slot. It also drives an inverted user output from the control register, an always-driven active-low interrupt, and an active-low receive reference pulse whose length comes from a two-bit field. The pad tri-state sits outside the block: the read data and an output-enable leave on separate ports.

Register slots, addressed by bus bits 2..0:
| Address | Name | Access | Contents |
|---|---|---|---|
| 0 | control | read/write | Bit 7 drives the user pin. |
| 1 | event status | read-only | Sticky event bits. |
| 2 | event enable | read/write | Per-bit interrupt enable. |
| 3 | configuration | read/write | Bits 4:3 set the pulse length. |
| 4 | live core status | read-only | Follows the core's status input. |
| 5, 6, 7 | general | read/write | Plain storage. |

Top module: `mbus_mgmt_port`

## Requirements
- R1: On a falling edge of `ale_i`, `ad_i[2:0]` is captured as the register address. Bits 7..3 play no part in addressing, so a write with the bus at 0xFD reaches slot 5.
- R2: While `cs_n_i` and `rd_n_i` are both low, `ad_oe_o` is 1 and `ad_o` carries the addressed slot. Otherwise `ad_oe_o` is 0 and `ad_o` is 0. A read strobe with select high therefore produces `ad_oe_o` = 0.
- R3: A byte on `ad_i` is stored when `wr_n_i` rises while `cs_n_i` is low. Two cases store nothing: a write strobe with select high, and a select released before the write strobe rises.
- R4: Slot 1 is read-only. Its bits are set by high bits of `irq_src_i` and stay set until read. When a read of slot 1 ends, only the bits returned by that read are cleared. A bit raised during the read stays pending, and a source high in the clearing cycle wins.
- R5: `irq_n_o` is low exactly when some bit is set in both slot 1 and slot 2. It is never unknown.
- R6: `user_n_o` is the inverse of slot 0 bit 7.
- R7: A one-cycle `rxref_trig_i` drives `rxref_n_o` low for 1, 2, 4 or 8 clocks. The length is selected by slot 3 bits 4:3 = 0, 1, 2, 3. Triggers that arrive while the pulse is running are ignored.
- R8: While `rst_n` is low, the following values hold. All stored slots and status are 0. `user_n_o` = 1, `irq_n_o` = 1 and `ad_oe_o` = 0. `rxref_n_o` = 1.
- R9: Slot 4 returns `core_stat_i` when read, and writes to it have no effect.
- R10: `regs_o[8*i+7:8*i]` carries slot i. Slot 1 appears there as the live status and slot 4 as `core_stat_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ale_i | input | 1 | Address latch strobe; its falling edge latches the address |
| cs_n_i | input | 1 | Chip select, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| ad_i | input | 8 | Shared bus, inbound value |
| ad_o | output | 8 | Shared bus, outbound read data |
| ad_oe_o | output | 1 | Bus output enable for the pad driver |
| user_n_o | output | 1 | User pin, inverse of control bit 7 |
| irq_n_o | output | 1 | Interrupt, active low, always driven |
| irq_src_i | input | 8 | Event sources from the core, one per status bit |
| core_stat_i | input | 8 | Live status from the core, readable at slot 4 |
| rxref_trig_i | input | 1 | Request for a receive reference pulse |
| rxref_n_o | output | 1 | Receive reference pulse, active low |
| regs_o | output | 64 | All eight register slots toward the core |

## Verification
Every bus input passes one sampling register before the bus controller sees it. As a result, `ad_oe_o` and `ad_o` become valid two clock edges after select and read go low, and a write lands in its slot two edges after the write strobe rises. A status bit and the interrupt respond one edge after the event source is sampled high, and the reference pulse goes low one edge after the trigger. The bench drives every input on a falling clock edge. It samples bus results only after at least three more falling edges, and it samples the interrupt and the pulse on the first falling edge after the causing rising edge. The pulse length is measured by counting low samples over a fixed window of twelve falling edges.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    // Bus and register file geometry
    localparam int DW   = 8;          // bus width
    localparam int AW   = 3;          // decoded address bits
    localparam int NREG = 1 << AW;    // register slots

    // Slot roles (the core decodes these positions)
    localparam int ADDR_CTRL = 0;
    localparam int ADDR_STAT = 1;
    localparam int ADDR_MASK = 2;
    localparam int ADDR_CFG  = 3;
    localparam int ADDR_LIVE = 4;

    // Field positions
    localparam int USR_BIT = 7;       // control bit driving the user pin
    localparam int PW_LSB  = 3;       // pulse length field, low bit
    localparam int PW_W    = 2;       // pulse length field width

    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_READ  = 2'd1,
        BUS_WRITE = 2'd2
    } bus_st_e;

    typedef enum logic {
        PL_IDLE   = 1'b0,
        PL_ACTIVE = 1'b1
    } pls_st_e;

    // Pulse length in clocks for a length code: 1, 2, 4, 8, ...
    function automatic int unsigned pulse_len(input int unsigned code);
        return 32'd1 << code;
    endfunction

endpackage

// File: rtl/mbus_insync.sv
module mbus_insync #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ale_i,
    input  logic          cs_n_i,
    input  logic          rd_n_i,
    input  logic          wr_n_i,
    input  logic [DW-1:0] ad_i,
    output logic          ale_q,
    output logic          ale_qq,
    output logic          cs_n_q,
    output logic          rd_n_q,
    output logic          wr_n_q,
    output logic [DW-1:0] ad_q
);

    // One sampling stage, plus a second ALE stage for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ale_q  <= 1'b0;
            ale_qq <= 1'b0;
            cs_n_q <= 1'b1;
            rd_n_q <= 1'b1;
            wr_n_q <= 1'b1;
            ad_q   <= '0;
        end else begin
            ale_q  <= ale_i;
            ale_qq <= ale_q;
            cs_n_q <= cs_n_i;
            rd_n_q <= rd_n_i;
            wr_n_q <= wr_n_i;
            ad_q   <= ad_i;
        end
    end

endmodule

// File: rtl/mbus_bus_fsm.sv
module mbus_bus_fsm
    import mbus_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ale_q,
    input  logic          ale_qq,
    input  logic          cs_n_q,
    input  logic          rd_n_q,
    input  logic          wr_n_q,
    input  logic [AW-1:0] adr_bits_i,
    output logic [AW-1:0] addr_o,
    output logic          rd_act_o,
    output logic          rd_start_o,
    output logic          rd_done_o,
    output logic          wr_stb_o
);

    bus_st_e state, nxt;
    logic    ale_fall;

    assign ale_fall = ale_qq && !ale_q;

    // State register and address latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= BUS_IDLE;
            addr_o <= '0;
        end else begin
            state <= nxt;
            if (ale_fall) begin
                addr_o <= adr_bits_i;
            end
        end
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            BUS_IDLE: begin
                if (!cs_n_q && !rd_n_q) begin
                    nxt = BUS_READ;
                end else if (!cs_n_q && !wr_n_q) begin
                    nxt = BUS_WRITE;
                end
            end
            BUS_READ: begin
                if (cs_n_q || rd_n_q) begin
                    nxt = BUS_IDLE;
                end
            end
            BUS_WRITE: begin
                if (cs_n_q || wr_n_q) begin
                    nxt = BUS_IDLE;
                end
            end
            default: nxt = BUS_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        rd_act_o   = (state == BUS_READ);
        rd_start_o = (state == BUS_IDLE) && (nxt == BUS_READ);
        rd_done_o  = (state == BUS_READ) && (nxt == BUS_IDLE);
        wr_stb_o   = (state == BUS_WRITE) && !cs_n_q && wr_n_q;
    end

endmodule

// File: rtl/mbus_regfile.sv
module mbus_regfile
    import mbus_pkg::*;
#(
    parameter int DW   = 8,
    parameter int AW   = 3,
    localparam int NR  = 1 << AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr_i,
    input  logic             wr_stb_i,
    input  logic [DW-1:0]    wr_data_i,
    input  logic             rd_start_i,
    input  logic             rd_done_i,
    input  logic [DW-1:0]    irq_src_i,
    input  logic [DW-1:0]    core_stat_i,
    output logic [DW-1:0]    rd_data_o,
    output logic [NR*DW-1:0] regs_o,
    output logic             irq_n_o
);

    logic [NR-1:0][DW-1:0] slot;
    logic [DW-1:0]         snap;
    logic                  sel_stat;

    assign sel_stat = (addr_i == AW'(ADDR_STAT));

    // Snapshot of status taken as a status read begins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap <= '0;
        end else if (rd_start_i && sel_stat) begin
            snap <= slot[ADDR_STAT];
        end
    end

    for (genvar i = 0; i < NR; i++) begin : g_slot
        if (i == ADDR_STAT) begin : g_stat
            logic [DW-1:0] st_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q <= '0;
                end else if (rd_done_i && sel_stat) begin
                    st_q <= (st_q & ~snap) | irq_src_i;
                end else begin
                    st_q <= st_q | irq_src_i;
                end
            end
            assign slot[i] = st_q;
        end else if (i == ADDR_LIVE) begin : g_live
            assign slot[i] = core_stat_i;
        end else begin : g_rw
            logic [DW-1:0] rw_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    rw_q <= '0;
                end else if (wr_stb_i && (addr_i == AW'(i))) begin
                    rw_q <= wr_data_i;
                end
            end
            assign slot[i] = rw_q;
        end
    end

    assign rd_data_o = sel_stat ? snap : slot[addr_i];
    assign regs_o    = slot;
    assign irq_n_o   = ~|(slot[ADDR_STAT] & slot[ADDR_MASK]);

endmodule

// File: rtl/mbus_refpulse.sv
module mbus_refpulse
    import mbus_pkg::*;
#(
    parameter int  PW_W  = 2,
    localparam int LEN_W = 1 << PW_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trig_i,
    input  logic [PW_W-1:0] sel_i,
    output logic            pulse_n_o
);

    pls_st_e          state, nxt;
    logic [LEN_W-1:0] cnt;

    // State register and down-counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= PL_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state == PL_IDLE && trig_i) begin
                cnt <= LEN_W'(pulse_len(32'(sel_i)) - 1);
            end else if (state == PL_ACTIVE && cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            PL_IDLE:   if (trig_i)     nxt = PL_ACTIVE;
            PL_ACTIVE: if (cnt == '0)  nxt = PL_IDLE;
            default:   nxt = PL_IDLE;
        endcase
    end

    // Output
    always_comb begin
        pulse_n_o = (state != PL_ACTIVE);
    end

endmodule

// File: rtl/mbus_mgmt_port.sv
module mbus_mgmt_port
    import mbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ale_i,
    input  logic             cs_n_i,
    input  logic             rd_n_i,
    input  logic             wr_n_i,
    input  logic [DW-1:0]    ad_i,
    output logic [DW-1:0]    ad_o,
    output logic             ad_oe_o,
    output logic             user_n_o,
    output logic             irq_n_o,
    input  logic [DW-1:0]    irq_src_i,
    input  logic [DW-1:0]    core_stat_i,
    input  logic             rxref_trig_i,
    output logic             rxref_n_o,
    output logic [NREG*DW-1:0] regs_o
);

    logic          ale_q, ale_qq, cs_n_q, rd_n_q, wr_n_q;
    logic [DW-1:0] ad_q;
    logic [AW-1:0] addr;
    logic          rd_act, rd_start, rd_done, wr_stb;
    logic [DW-1:0] rd_data;

    mbus_insync #(.DW(DW)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .ale_i  (ale_i),
        .cs_n_i (cs_n_i),
        .rd_n_i (rd_n_i),
        .wr_n_i (wr_n_i),
        .ad_i   (ad_i),
        .ale_q  (ale_q),
        .ale_qq (ale_qq),
        .cs_n_q (cs_n_q),
        .rd_n_q (rd_n_q),
        .wr_n_q (wr_n_q),
        .ad_q   (ad_q)
    );

    mbus_bus_fsm #(.AW(AW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ale_q      (ale_q),
        .ale_qq     (ale_qq),
        .cs_n_q     (cs_n_q),
        .rd_n_q     (rd_n_q),
        .wr_n_q     (wr_n_q),
        .adr_bits_i (ad_q[AW-1:0]),
        .addr_o     (addr),
        .rd_act_o   (rd_act),
        .rd_start_o (rd_start),
        .rd_done_o  (rd_done),
        .wr_stb_o   (wr_stb)
    );

    mbus_regfile #(.DW(DW), .AW(AW)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr_i      (addr),
        .wr_stb_i    (wr_stb),
        .wr_data_i   (ad_q),
        .rd_start_i  (rd_start),
        .rd_done_i   (rd_done),
        .irq_src_i   (irq_src_i),
        .core_stat_i (core_stat_i),
        .rd_data_o   (rd_data),
        .regs_o      (regs_o),
        .irq_n_o     (irq_n_o)
    );

    mbus_refpulse #(.PW_W(PW_W)) u_pulse (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_i    (rxref_trig_i),
        .sel_i     (regs_o[ADDR_CFG*DW+PW_LSB +: PW_W]),
        .pulse_n_o (rxref_n_o)
    );

    assign ad_oe_o  = rd_act;
    assign ad_o     = rd_act ? rd_data : '0;
    assign user_n_o = ~regs_o[ADDR_CTRL*DW+USR_BIT];

endmodule

// File: rtl/mbus_mgmt_port_chk.sv
module mbus_mgmt_port_chk
    import mbus_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            cs_n_i,
    input logic            rd_n_i,
    input logic            ad_oe_o,
    input logic            user_n_o,
    input logic            irq_n_o,
    input logic            rxref_n_o,
    input logic [DW-1:0]   irq_src_i,
    input logic [DW-1:0]   ctrl_slot,
    input logic [DW-1:0]   stat_slot,
    input logic [DW-1:0]   mask_slot,
    input logic [PW_W-1:0] pw_code
);

    logic [7:0] low_cnt;
    logic [7:0] wid_q;
    logic       ref_prev;

    // Counts consecutive low samples of the reference pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt  <= '0;
            wid_q    <= 8'd1;
            ref_prev <= 1'b1;
        end else begin
            ref_prev <= rxref_n_o;
            low_cnt  <= rxref_n_o ? 8'd0 : low_cnt + 8'd1;
            if (ref_prev && !rxref_n_o) begin
                wid_q <= 8'(pulse_len(32'(pw_code)));
            end
        end
    end

    // R2: bus driven only two edges after select and read were low
    a_r2_oe_from_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe_o |-> $past(!cs_n_i && !rd_n_i, 2));

    // R4: a source high in a cycle is always set in status afterwards
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_slot & $past(irq_src_i)) == $past(irq_src_i)));

    // R5: interrupt is always a known level
    a_r5_irq_known: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown(irq_n_o));

    // R5: interrupt needs an enable bit
    a_r5_irq_needs_mask: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n_o |-> (mask_slot != '0));

    // R6: user pin inverse of control bit 7
    a_r6_user_pin: assert property (@(posedge clk) disable iff (!rst_n)
        user_n_o == !ctrl_slot[USR_BIT]);

    // R7: pulse length matches the code in force when it started
    a_r7_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rxref_n_o) |-> (low_cnt == wid_q));

    // R8: outputs idle after a reset cycle
    a_r8_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (irq_n_o && user_n_o && !ad_oe_o && rxref_n_o));

endmodule

bind mbus_mgmt_port mbus_mgmt_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n_i    (cs_n_i),
    .rd_n_i    (rd_n_i),
    .ad_oe_o   (ad_oe_o),
    .user_n_o  (user_n_o),
    .irq_n_o   (irq_n_o),
    .rxref_n_o (rxref_n_o),
    .irq_src_i (irq_src_i),
    .ctrl_slot (regs_o[mbus_pkg::ADDR_CTRL*mbus_pkg::DW +: mbus_pkg::DW]),
    .stat_slot (regs_o[mbus_pkg::ADDR_STAT*mbus_pkg::DW +: mbus_pkg::DW]),
    .mask_slot (regs_o[mbus_pkg::ADDR_MASK*mbus_pkg::DW +: mbus_pkg::DW]),
    .pw_code   (regs_o[mbus_pkg::ADDR_CFG*mbus_pkg::DW+mbus_pkg::PW_LSB +: mbus_pkg::PW_W])
);

// File: tb/sim_mbus_mgmt_port.sv
`timescale 1ns/1ps
module sim_mbus_mgmt_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ale_i = 1'b0;
    logic        cs_n_i = 1'b1;
    logic        rd_n_i = 1'b1;
    logic        wr_n_i = 1'b1;
    logic [7:0]  ad_i = 8'h00;
    logic [7:0]  ad_o;
    logic        ad_oe_o;
    logic        user_n_o;
    logic        irq_n_o;
    logic [7:0]  irq_src_i = 8'h00;
    logic [7:0]  core_stat_i = 8'h00;
    logic        rxref_trig_i = 1'b0;
    logic        rxref_n_o;
    logic [63:0] regs_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mbus_mgmt_port u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .ale_i        (ale_i),
        .cs_n_i       (cs_n_i),
        .rd_n_i       (rd_n_i),
        .wr_n_i       (wr_n_i),
        .ad_i         (ad_i),
        .ad_o         (ad_o),
        .ad_oe_o      (ad_oe_o),
        .user_n_o     (user_n_o),
        .irq_n_o      (irq_n_o),
        .irq_src_i    (irq_src_i),
        .core_stat_i  (core_stat_i),
        .rxref_trig_i (rxref_trig_i),
        .rxref_n_o    (rxref_n_o),
        .regs_o       (regs_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic latch_addr(input logic [7:0] a);
        @(negedge clk);
        ad_i  = a;
        ale_i = 1'b1;
        idle(2);
        ale_i = 1'b0;
        idle(2);
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        latch_addr(a);
        ad_i   = d;
        cs_n_i = 1'b0;
        wr_n_i = 1'b0;
        idle(3);
        wr_n_i = 1'b1;
        idle(3);
        cs_n_i = 1'b1;
        idle(2);
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d, output logic oe);
        latch_addr(a);
        cs_n_i = 1'b0;
        rd_n_i = 1'b0;
        idle(4);
        d  = ad_o;
        oe = ad_oe_o;
        rd_n_i = 1'b1;
        cs_n_i = 1'b1;
        idle(4);
    endtask

    task automatic t_reset();
        check("R8 irq_n", 64'(irq_n_o), 64'd1);
        check("R8 user_n", 64'(user_n_o), 64'd1);
        check("R8 ad_oe", 64'(ad_oe_o), 64'd0);
        check("R8 rxref_n", 64'(rxref_n_o), 64'd1);
        check("R8 slots", regs_o & ~64'hFF_0000_0000, 64'd0);
    endtask

    task automatic t_rw_decode();
        logic [7:0] d;
        logic oe;
        bus_write(8'hFD, 8'h5A);
        check("R1 upper bits ignored", 64'(regs_o[47:40]), 64'h5A);
        bus_read(8'h05, d, oe);
        check("R2 read data", 64'(d), 64'h5A);
        check("R2 read oe", 64'(oe), 64'd1);
        bus_write(8'h07, 8'hC3);
        check("R10 slot 7 export", 64'(regs_o[63:56]), 64'hC3);
        check("R2 idle oe", 64'(ad_oe_o), 64'd0);
    endtask

    task automatic t_rd_no_select();
        latch_addr(8'h05);
        rd_n_i = 1'b0;
        idle(4);
        check("R2 no select no drive", {56'd0, ad_o, 7'd0, ad_oe_o}, 64'd0);
        rd_n_i = 1'b1;
        idle(2);
    endtask

    task automatic t_write_ignored();
        latch_addr(8'h06);
        ad_i   = 8'h77;
        wr_n_i = 1'b0;
        idle(3);
        wr_n_i = 1'b1;
        idle(3);
        check("R3 write without select", 64'(regs_o[55:48]), 64'h00);
        ad_i   = 8'h99;
        cs_n_i = 1'b0;
        wr_n_i = 1'b0;
        idle(3);
        cs_n_i = 1'b1;
        idle(3);
        wr_n_i = 1'b1;
        idle(3);
        check("R3 select dropped first", 64'(regs_o[55:48]), 64'h00);
    endtask

    task automatic t_user_pin();
        bus_write(8'h00, 8'h80);
        check("R6 user pin low", 64'(user_n_o), 64'd0);
        bus_write(8'h00, 8'h7F);
        check("R6 user pin high", 64'(user_n_o), 64'd1);
    endtask

    task automatic t_status_irq();
        logic [7:0] d;
        logic oe;
        bus_write(8'h02, 8'h01);
        @(negedge clk) irq_src_i = 8'h01;
        @(negedge clk) irq_src_i = 8'h00;
        check("R5 irq asserted", 64'(irq_n_o), 64'd0);
        bus_write(8'h01, 8'h00);
        check("R4 status read-only", 64'(regs_o[15:8]), 64'h01);
        bus_read(8'h01, d, oe);
        check("R4 status read", 64'(d), 64'h01);
        check("R5 irq released", 64'(irq_n_o), 64'd1);
        @(negedge clk) irq_src_i = 8'h04;
        @(negedge clk) irq_src_i = 8'h00;
        check("R5 masked bit no irq", 64'(irq_n_o), 64'd1);
        check("R4 masked bit sticky", 64'(regs_o[15:8]), 64'h04);
        // bit raised while a status read is in progress
        latch_addr(8'h01);
        cs_n_i = 1'b0;
        rd_n_i = 1'b0;
        idle(4);
        check("R4 snapshot", 64'(ad_o), 64'h04);
        irq_src_i = 8'h02;
        @(negedge clk) irq_src_i = 8'h00;
        idle(2);
        rd_n_i = 1'b1;
        cs_n_i = 1'b1;
        idle(4);
        check("R4 late bit kept", 64'(regs_o[15:8]), 64'h02);
        bus_read(8'h01, d, oe);
        check("R4 late bit read", 64'(d), 64'h02);
        check("R4 cleared", 64'(regs_o[15:8]), 64'h00);
    endtask

    task automatic t_live();
        logic [7:0] d;
        logic oe;
        core_stat_i = 8'hA6;
        bus_write(8'h04, 8'h11);
        bus_read(8'h04, d, oe);
        check("R9 live read", 64'(d), 64'hA6);
        check("R10 live export", 64'(regs_o[39:32]), 64'hA6);
    endtask

    task automatic t_pulse(input int code, input bit retrig);
        int lows;
        bus_write(8'h03, 8'(code << 3));
        @(negedge clk) rxref_trig_i = 1'b1;
        lows = 0;
        for (int j = 0; j < 12; j++) begin
            @(negedge clk);
            rxref_trig_i = (retrig && j == 1);
            if (!rxref_n_o) lows++;
        end
        rxref_trig_i = 1'b0;
        check(retrig ? "R7 retrigger ignored" : "R7 pulse length",
              64'(lows), 64'(1 << code));
    endtask

    initial begin
        idle(3);
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_rw_decode();
        t_rd_no_select();
        t_write_ignored();
        t_user_pin();
        t_status_irq();
        t_live();
        for (int c = 0; c < 4; c++) t_pulse(c, 1'b0);
        t_pulse(2, 1'b1);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule